// File: doc/BRIEF.md
# Acknowledge Polling Sequencer

This block sits on the master side of a two-wire serial memory bus. It waits out the memory's internal nonvolatile write cycle. The host first finishes a byte load with a STOP and then pulses `go`. From that point the sequencer runs polling attempts. Each attempt is a START followed by the slave address byte. A slave that is still programming leaves the acknowledge slot high, so the sequencer closes the attempt with a STOP and tries again.

When an acknowledge finally comes back, the write cycle is over and the block takes one of two exits, chosen when `go` was taken. In the first exit it releases the bus with a STOP. In the second it hands the still-open transfer back to the host, which can carry on with a normal read or write command without a new START. If the acknowledge does not arrive within a set number of attempts, the sequencer gives up, releases the bus and raises a timeout flag.

The sequencer does not drive the pads. Each bus action is a request to a bit-level engine, which reports completion with a ready strobe. For a sent byte, the engine also returns the acknowledge it sampled.

Top module: `ackpoll_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `cmd_req` and `timeout` are all low.
- R2: The first bus command after an accepted `go` is a START (`cmd_op` = 0). No STOP comes before it.
- R3: Each polling attempt is a START followed by a send-byte command (`cmd_op` = 2). The byte carries the 7-bit device address in bits 7..1 and the read/write selection in bit 0, where 1 means read.
- R4: When a sent address byte completes with `cmd_ack` = 0, the next command is a STOP (`cmd_op` = 1). If attempts remain, another START follows that STOP.
- R5: When the address byte is acknowledged and release mode was chosen, the sequencer issues one STOP and then ends with `done_ok` = 1.
- R6: When the address byte is acknowledged and hold mode was chosen, the sequencer ends with `done_ok` = 1 straight after that byte and issues no STOP.
- R7: After `MAX_TRIES` unacknowledged attempts, the sequencer issues a STOP and ends with `done_ok` = 0. It also sets `timeout`, which stays high until the next accepted `go`.
- R8: A command request keeps `cmd_op` and `cmd_data` stable until `cmd_rdy` is seen, and each ready strobe completes exactly one command.
- R9: `done` is high for exactly one clock per accepted `go`, in the cycle after the final handshake.
- R10: `go` is ignored while `busy` is high. The address, the read/write selection and the exit mode are all captured when `go` is accepted, so changes to those inputs during a run have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Begin polling (taken only when idle) |
| dev_addr | input | 7 | Device address for the polling byte |
| poll_rd | input | 1 | R/W bit value for the polling byte (1 = read) |
| hold_bus | input | 1 | 1: keep the transfer open after acknowledge; 0: end with STOP |
| busy | output | 1 | A polling run is in progress |
| done | output | 1 | One-clock pulse when a run ends |
| done_ok | output | 1 | Status of the last run: 1 acknowledged, 0 timed out |
| timeout | output | 1 | Set on attempt exhaustion, cleared by the next accepted go |
| cmd_req | output | 1 | Command request to the bus engine |
| cmd_op | output | 2 | Command: 0 START, 1 STOP, 2 send byte |
| cmd_data | output | 8 | Byte to send for the send-byte command |
| cmd_rdy | input | 1 | Engine completion strobe for the current command |
| cmd_ack | input | 1 | Acknowledge sampled for a sent byte (1 = acknowledged), valid with cmd_rdy |

## Verification
If the state register goes wrong, the fault shows up on the command port at the very next handshake. A STOP can appear where a START was due, a retry can be skipped after a missed acknowledge, or a STOP can be sent in hold mode. A wrong attempt count shows up as a command stream that is one attempt short or one attempt long, and as `done` arriving on the wrong handshake. Lost capture of the run's settings shows up in bit 0 or the upper bits of the address byte within a single attempt.

// File: rtl/ackpoll_pkg.sv
package ackpoll_pkg;

    localparam int DEV_ADDR_W = 7;
    localparam int BYTE_W     = DEV_ADDR_W + 1;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_STOP  = 2'd1,
        OP_SEND  = 2'd2
    } bus_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_ADDR,
        ST_STOP_RETRY,
        ST_STOP_OK,
        ST_STOP_FAIL
    } poll_state_e;

    typedef struct packed {
        logic [DEV_ADDR_W-1:0] addr;
        logic                  rd;
        logic                  hold;
    } poll_cfg_t;

    function automatic logic [BYTE_W-1:0] addr_byte(input poll_cfg_t c);
        return {c.addr, c.rd};
    endfunction

endpackage

// File: rtl/ackpoll_try_ctr.sv
module ackpoll_try_ctr #(
    parameter int MAX_TRIES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic bump,
    output logic last_try
);
    localparam int CNT_W = (MAX_TRIES < 2) ? 1 : $clog2(MAX_TRIES + 1);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(MAX_TRIES - 1);

    logic [CNT_W-1:0] tries_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            tries_q <= '0;
        end else if (bump && tries_q != LAST_IDX) begin
            tries_q <= tries_q + 1'b1;
        end
    end

    // the attempt now being judged is the final one allowed
    assign last_try = (tries_q == LAST_IDX);
endmodule

// File: rtl/ackpoll_fsm.sv
module ackpoll_fsm
    import ackpoll_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        go,
    input  logic        cmd_rdy,
    input  logic        cmd_ack,
    input  logic        last_try,
    input  logic        hold,
    output poll_state_e state,
    output logic        launch,
    output logic        bump,
    output logic        finish,
    output logic        finish_ok
);
    poll_state_e st_q, st_d;

    always_comb begin
        st_d      = st_q;
        launch    = 1'b0;
        bump      = 1'b0;
        finish    = 1'b0;
        finish_ok = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (go) begin
                    st_d   = ST_START;
                    launch = 1'b1;
                end
            end
            ST_START: begin
                if (cmd_rdy) st_d = ST_ADDR;
            end
            ST_ADDR: begin
                if (cmd_rdy) begin
                    if (cmd_ack) begin
                        if (hold) begin
                            st_d      = ST_IDLE;
                            finish    = 1'b1;
                            finish_ok = 1'b1;
                        end else begin
                            st_d = ST_STOP_OK;
                        end
                    end else begin
                        bump = 1'b1;
                        st_d = last_try ? ST_STOP_FAIL : ST_STOP_RETRY;
                    end
                end
            end
            ST_STOP_RETRY: begin
                if (cmd_rdy) st_d = ST_START;
            end
            ST_STOP_OK: begin
                if (cmd_rdy) begin
                    st_d      = ST_IDLE;
                    finish    = 1'b1;
                    finish_ok = 1'b1;
                end
            end
            ST_STOP_FAIL: begin
                if (cmd_rdy) begin
                    st_d   = ST_IDLE;
                    finish = 1'b1;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    assign state = st_q;
endmodule

// File: rtl/ackpoll_cmd_gen.sv
module ackpoll_cmd_gen
    import ackpoll_pkg::*;
(
    input  poll_state_e       state,
    input  poll_cfg_t         cfg,
    output logic              req,
    output bus_op_e           op,
    output logic [BYTE_W-1:0] data
);
    always_comb begin
        req  = 1'b1;
        op   = OP_START;
        data = '0;
        unique case (state)
            ST_IDLE:  req = 1'b0;
            ST_START: op  = OP_START;
            ST_ADDR: begin
                op   = OP_SEND;
                data = addr_byte(cfg);
            end
            ST_STOP_RETRY, ST_STOP_OK, ST_STOP_FAIL: op = OP_STOP;
            default: req = 1'b0;
        endcase
    end
endmodule

// File: rtl/ackpoll_seq.sv
module ackpoll_seq
    import ackpoll_pkg::*;
#(
    parameter int MAX_TRIES = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  go,
    input  logic [DEV_ADDR_W-1:0] dev_addr,
    input  logic                  poll_rd,
    input  logic                  hold_bus,
    output logic                  busy,
    output logic                  done,
    output logic                  done_ok,
    output logic                  timeout,
    output logic                  cmd_req,
    output logic [1:0]            cmd_op,
    output logic [BYTE_W-1:0]     cmd_data,
    input  logic                  cmd_rdy,
    input  logic                  cmd_ack
);
    poll_state_e state;
    poll_cfg_t   cfg_q;
    bus_op_e     op_w;
    logic        launch, bump, finish, finish_ok, last_try;
    logic        done_q, ok_q, to_q;

    ackpoll_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .go        (go),
        .cmd_rdy   (cmd_rdy),
        .cmd_ack   (cmd_ack),
        .last_try  (last_try),
        .hold      (cfg_q.hold),
        .state     (state),
        .launch    (launch),
        .bump      (bump),
        .finish    (finish),
        .finish_ok (finish_ok)
    );

    ackpoll_try_ctr #(.MAX_TRIES(MAX_TRIES)) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .clear    (launch),
        .bump     (bump),
        .last_try (last_try)
    );

    ackpoll_cmd_gen u_cmd (
        .state (state),
        .cfg   (cfg_q),
        .req   (cmd_req),
        .op    (op_w),
        .data  (cmd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            done_q <= 1'b0;
            ok_q   <= 1'b0;
            to_q   <= 1'b0;
        end else begin
            done_q <= finish;
            if (launch) begin
                cfg_q <= '{addr: dev_addr, rd: poll_rd, hold: hold_bus};
                to_q  <= 1'b0;
            end
            if (finish) begin
                ok_q <= finish_ok;
                if (!finish_ok) to_q <= 1'b1;
            end
        end
    end

    assign cmd_op  = op_w;
    assign busy    = (state != ST_IDLE);
    assign done    = done_q;
    assign done_ok = ok_q;
    assign timeout = to_q;
endmodule

// File: rtl/ackpoll_seq_chk.sv
module ackpoll_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       busy,
    input logic       done,
    input logic       done_ok,
    input logic       timeout,
    input logic       cmd_req,
    input logic [1:0] cmd_op,
    input logic [7:0] cmd_data,
    input logic       cmd_rdy,
    input logic       cmd_ack
);
    p_req_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (cmd_req && !cmd_rdy) |=> (cmd_req && $stable(cmd_op) && $stable(cmd_data)));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_first_start_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (cmd_req && cmd_op == 2'd0));

    p_nack_stop_r4: assert property (@(posedge clk) disable iff (rst)
        (cmd_req && cmd_rdy && cmd_op == 2'd2 && !cmd_ack) |=> (cmd_req && cmd_op == 2'd1));

    p_ack_exit_r6: assert property (@(posedge clk) disable iff (rst)
        (cmd_req && cmd_rdy && cmd_op == 2'd2 && cmd_ack) |=>
            ((done && done_ok && !busy) || (cmd_req && cmd_op == 2'd1)));

    p_fail_flag_r7: assert property (@(posedge clk) disable iff (rst)
        (done && !done_ok) |-> timeout);

    p_ok_noflag_r5: assert property (@(posedge clk) disable iff (rst)
        (done && done_ok) |-> !timeout);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !cmd_req);
endmodule

bind ackpoll_seq ackpoll_seq_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .done     (done),
    .done_ok  (done_ok),
    .timeout  (timeout),
    .cmd_req  (cmd_req),
    .cmd_op   (cmd_op),
    .cmd_data (cmd_data),
    .cmd_rdy  (cmd_rdy),
    .cmd_ack  (cmd_ack)
);

// File: tb/ackpoll_seq_test.sv
`timescale 1ns/1ps
module ackpoll_seq_test;
    localparam int TRIES = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       go = 1'b0;
    logic [6:0] dev_addr = '0;
    logic       poll_rd = 1'b0;
    logic       hold_bus = 1'b0;
    logic       busy, done, done_ok, timeout, cmd_req;
    logic [1:0] cmd_op;
    logic [7:0] cmd_data;
    logic       cmd_rdy = 1'b0;
    logic       cmd_ack = 1'b0;

    int checks = 0;
    int errors = 0;

    // bench bus engine model
    logic [1:0] op_log [64];
    logic [7:0] dat_log [64];
    int n_cmd = 0;
    int nacks_left = 0;
    int wait_cnt = 0;
    int done_cnt = 0;
    logic last_ok = 1'b0;

    always #2 clk = ~clk;

    ackpoll_seq #(.MAX_TRIES(TRIES)) uut (
        .clk(clk), .rst(rst), .go(go), .dev_addr(dev_addr), .poll_rd(poll_rd),
        .hold_bus(hold_bus), .busy(busy), .done(done), .done_ok(done_ok),
        .timeout(timeout), .cmd_req(cmd_req), .cmd_op(cmd_op), .cmd_data(cmd_data),
        .cmd_rdy(cmd_rdy), .cmd_ack(cmd_ack)
    );

    always @(negedge clk) begin
        if (done) begin
            done_cnt = done_cnt + 1;
            last_ok  = done_ok;
        end
        if (cmd_rdy) begin
            cmd_rdy  = 1'b0;
            cmd_ack  = 1'b0;
            wait_cnt = 0;
        end else if (cmd_req && !rst) begin
            wait_cnt = wait_cnt + 1;
            if (wait_cnt >= 2) begin
                if (n_cmd < 64) begin
                    op_log[n_cmd]  = cmd_op;
                    dat_log[n_cmd] = cmd_data;
                end
                n_cmd = n_cmd + 1;
                cmd_rdy = 1'b1;
                if (cmd_op == 2'd2) begin
                    if (nacks_left == 0) cmd_ack = 1'b1;
                    else begin
                        cmd_ack = 1'b0;
                        if (nacks_left > 0) nacks_left = nacks_left - 1;
                    end
                end
            end
        end
    end

    initial begin
        #400000;
        errors = errors + 1;
        $display("FAIL watchdog expired: act hung exp finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic chk(input string req, input logic ok, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s act %0d exp %0d", req, act, exp);
        end
    endtask

    task automatic pulse_go(input logic [6:0] a, input logic rd, input logic hold);
        @(negedge clk);
        dev_addr = a; poll_rd = rd; hold_bus = hold; go = 1'b1;
        @(negedge clk);
        go = 1'b0;
    endtask

    task automatic wait_done(input int start_cnt);
        for (int i = 0; i < 3000 && done_cnt == start_cnt; i++) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    // compare the recorded command stream against the expected one
    task automatic verify(input logic [6:0] a, input logic rd, input logic hold,
                          input int nacks, input int d0);
        int tries;
        int k;
        bit ok;
        logic [7:0] exp_byte;
        ok = (nacks >= 0 && nacks < TRIES);
        tries = ok ? nacks + 1 : TRIES;
        exp_byte = {a, rd};
        k = 0;
        chk("R2 first command START", n_cmd > 0 && op_log[0] == 2'd0, int'(op_log[0]), 0);
        for (int t = 0; t < tries; t++) begin
            chk("R3 attempt opens with START", op_log[k] == 2'd0, int'(op_log[k]), 0);
            chk("R3 address byte sent", op_log[k+1] == 2'd2 && dat_log[k+1] == exp_byte,
                int'(dat_log[k+1]), int'(exp_byte));
            k = k + 2;
            if (t < tries - 1 || !ok) begin
                chk("R4 STOP after missing ack", op_log[k] == 2'd1, int'(op_log[k]), 1);
                k = k + 1;
            end else if (!hold) begin
                chk("R5 STOP after ack", op_log[k] == 2'd1, int'(op_log[k]), 1);
                k = k + 1;
            end
        end
        if (hold && ok) chk("R6 no STOP in hold mode", n_cmd == k, n_cmd, k);
        else if (ok)    chk("R5 command count", n_cmd == k, n_cmd, k);
        else            chk("R7 attempts bounded", n_cmd == k, n_cmd, k);
        chk("R9 single done pulse", done_cnt == d0 + 1, done_cnt - d0, 1);
        chk(ok ? "R5 done_ok set" : "R7 done_ok clear", last_ok == ok, int'(last_ok), int'(ok));
        chk("R7 timeout flag", timeout == !ok, int'(timeout), int'(!ok));
        chk("R1 idle after run", !busy && !cmd_req, int'(busy), 0);
    endtask

    task automatic run(input logic [6:0] a, input logic rd, input logic hold, input int nacks);
        int d0;
        d0 = done_cnt;
        n_cmd = 0;
        nacks_left = nacks;
        pulse_go(a, rd, hold);
        wait_done(d0);
        verify(a, rd, hold, nacks, d0);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 busy low", !busy, int'(busy), 0);
        chk("R1 done low", !done, int'(done), 0);
        chk("R1 cmd_req low", !cmd_req, int'(cmd_req), 0);
        chk("R1 timeout low", !timeout, int'(timeout), 0);
    endtask

    task automatic t_immediate_ack();  run(7'h50, 1'b0, 1'b0, 0); endtask
    task automatic t_retry_read();     run(7'h2B, 1'b1, 1'b0, 3); endtask
    task automatic t_hold_exit();      run(7'h11, 1'b0, 1'b1, 2); endtask
    task automatic t_exhaust();        run(7'h7F, 1'b1, 1'b0, -1); endtask
    task automatic t_last_chance();    run(7'h01, 1'b0, 1'b1, TRIES - 1); endtask

    task automatic t_go_while_busy();
        int d0;
        d0 = done_cnt;
        n_cmd = 0;
        nacks_left = 2;
        pulse_go(7'h35, 1'b0, 1'b0);
        repeat (5) @(negedge clk);
        chk("R10 busy during run", busy, int'(busy), 1);
        // try to restart with different settings; must be ignored (R10)
        dev_addr = 7'h0A; poll_rd = 1'b1; hold_bus = 1'b1; go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        repeat (3) @(negedge clk);
        wait_done(d0);
        dev_addr = 7'h00;
        verify(7'h35, 1'b0, 1'b0, 2, d0);
    endtask

    initial begin
        t_reset();
        t_immediate_ack();
        t_retry_read();
        t_hold_exit();
        t_exhaust();
        t_immediate_ack();
        t_last_chance();
        t_go_while_busy();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule